// File: doc/BRIEF.md
# Exception-Entry Address-Register Hazard Guard

This block sits beside the decode stage of a DSP address-generation unit and guards the first instruction cycles of an exception service routine. The modulo-control setting that governs address updates is not yet reliable in those cycles. Any instruction that depends on it through a low-bank address register must therefore be caught. The guard sees a one-cycle exception-entry pulse and, for each issue slot, a valid strobe and a few pre-decoded fields: the address register read, the addressing mode, whether the instruction is address arithmetic, and its destination register.

A small window counter is loaded on exception entry. It counts down on each cycle in which an instruction issues or a stall is requested. While the count is nonzero, each slot raises a combinational hazard flag if its instruction is modifier-affected on registers below the bank limit. Post-update and pre-calculated addressing are modifier-affected. Address arithmetic is judged by its destination alone. In stall mode a registered stall request follows a detected hazard. The stalled cycle uses up part of the window, so the held instruction later issues cleanly.

Top module: `agu_exc_hazard_guard`

## Requirements
- R1: While `rst_ni` is low and after its release, `stall_o` is 0 and the window is closed, so `hazard_o` is all zero until the first exception-entry pulse.
- R2: An exception-entry pulse opens a window of WINDOW (default 2) counted cycles. A counted cycle is one where any slot is valid or `stall_o` is 1. A modifier-affected instruction is a hazard in the first and second counted cycles and is allowed from the third on.
- R3: A non-arithmetic access through register index 8 or higher (the high bank, index >= LOW_BANK) never raises the hazard.
- R4: Inside the window, a valid access to register index 0..7 with mode 2'b10 (post-update) raises the hazard flag of its slot.
- R5: Inside the window, a valid access to register index 0..7 with mode 2'b11 (pre-calculated address) raises the hazard flag of its slot.
- R6: Mode 2'b01 (indirect, no update) and mode 2'b00 (no address access) never raise the hazard, even on registers 0..7 inside the window.
- R7: When `wr_areg_i` is 1 (address arithmetic), only `dst_idx_i` decides. A destination in 0..7 is a hazard inside the window. A destination of 8 or higher is allowed whatever the source register and mode.
- R8: A valid no-operation (mode 2'b00, `wr_areg_i` 0) uses up one window cycle. A cycle with no valid slot and `stall_o` at 0 does not.
- R9: An exception-entry pulse while the window is open reloads it to the full WINDOW count. The pulse takes priority over the decrement in the same cycle.
- R10: Slots are classified independently. A slot with its valid bit at 0 never raises its hazard bit. Several valid slots in one cycle use up a single window cycle.
- R11: `stall_o` is registered. It is 1 in the cycle after a cycle in which `stall_en_i` was 1 and any hazard bit was set, and 0 otherwise.
- R12: A cycle with `stall_o` at 1 counts against the window even when no slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_entry_i | input | 1 | One-cycle pulse on entry to an exception service routine |
| stall_en_i | input | 1 | 1 selects stall mode, 0 selects flag-only mode |
| valid_i | input | NUM_SLOTS | Instruction valid per issue slot |
| areg_idx_i | input | NUM_SLOTS x AREG_W | Address register read by each slot |
| mode_i | input | NUM_SLOTS x 2 | Addressing mode: 00 none, 01 indirect, 10 post-update, 11 pre-calculated |
| wr_areg_i | input | NUM_SLOTS | Slot is address arithmetic writing an address register |
| dst_idx_i | input | NUM_SLOTS x AREG_W | Destination address register of address arithmetic |
| hazard_o | output | NUM_SLOTS | Combinational hazard flag per slot |
| stall_o | output | 1 | Registered stall request |

## Verification
Modifier-affected accesses are placed in the first, second and third counted cycles after entry. This separates a window that is too short from one that is too long. Leading no-operations and idle gaps are mixed in to show which cycles are counted. High-bank and low-bank registers are crossed with every addressing mode, and address arithmetic is crossed with source and destination banks, so that a classifier keyed on the wrong field is exposed. Re-entry within an open window, dual-slot issue with a masked slot, and a stalled cycle with no valid slot each check a different rule for advancing the window.

// File: rtl/agu_hzd_pkg.sv
package agu_hzd_pkg;
  typedef enum logic [1:0] {
    AM_NONE = 2'b00,
    AM_IND  = 2'b01,
    AM_POST = 2'b10,
    AM_PRE  = 2'b11
  } addr_mode_e;
endpackage

// File: rtl/agu_hzd_slot_class.sv
module agu_hzd_slot_class
  import agu_hzd_pkg::*;
#(
  parameter int AREG_W   = 4,
  parameter int LOW_BANK = 8
) (
  input  logic              valid_i,
  input  logic              win_active_i,
  input  logic [AREG_W-1:0] areg_idx_i,
  input  logic [1:0]        mode_i,
  input  logic              wr_areg_i,
  input  logic [AREG_W-1:0] dst_idx_i,
  output logic              hazard_o
);
  localparam logic [AREG_W-1:0] LOW_LIM = AREG_W'(LOW_BANK);

  addr_mode_e mode;
  logic src_low, dst_low, mod_use;

  assign mode    = addr_mode_e'(mode_i);
  assign src_low = areg_idx_i < LOW_LIM;
  assign dst_low = dst_idx_i < LOW_LIM;

  always_comb begin
    if (wr_areg_i) begin
      mod_use = dst_low;  // arithmetic: destination decides
    end else begin
      unique case (mode)
        AM_POST, AM_PRE: mod_use = src_low;
        default:         mod_use = 1'b0;
      endcase
    end
  end

  assign hazard_o = valid_i & win_active_i & mod_use;
endmodule

// File: rtl/agu_hzd_window.sv
module agu_hzd_window #(
  parameter int WINDOW = 2,
  localparam int CNT_W = $clog2(WINDOW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_entry_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (exc_entry_i) begin
      cnt_q <= CNT_W'(WINDOW);
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = cnt_q != '0;
endmodule

// File: rtl/agu_hzd_stall.sv
module agu_hzd_stall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_en_i,
  input  logic any_hazard_i,
  output logic stall_o
);
  logic stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= stall_en_i & any_hazard_i;
  end

  assign stall_o = stall_q;
endmodule

// File: rtl/agu_exc_hazard_guard.sv
module agu_exc_hazard_guard #(
  parameter int NUM_SLOTS = 2,
  parameter int AREG_W    = 4,
  parameter int LOW_BANK  = 8,
  parameter int WINDOW    = 2,
  localparam int CNT_W    = $clog2(WINDOW + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              exc_entry_i,
  input  logic                              stall_en_i,
  input  logic [NUM_SLOTS-1:0]              valid_i,
  input  logic [NUM_SLOTS-1:0][AREG_W-1:0]  areg_idx_i,
  input  logic [NUM_SLOTS-1:0][1:0]         mode_i,
  input  logic [NUM_SLOTS-1:0]              wr_areg_i,
  input  logic [NUM_SLOTS-1:0][AREG_W-1:0]  dst_idx_i,
  output logic [NUM_SLOTS-1:0]              hazard_o,
  output logic                              stall_o
);
  logic [CNT_W-1:0] win_cnt;
  logic win_active, tick, any_hazard;

  assign tick       = (|valid_i) | stall_o;  // stalled cycle also counts
  assign any_hazard = |hazard_o;

  agu_hzd_window #(.WINDOW(WINDOW)) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_entry_i (exc_entry_i),
    .tick_i      (tick),
    .cnt_o       (win_cnt),
    .active_o    (win_active)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    agu_hzd_slot_class #(.AREG_W(AREG_W), .LOW_BANK(LOW_BANK)) u_class (
      .valid_i      (valid_i[s]),
      .win_active_i (win_active),
      .areg_idx_i   (areg_idx_i[s]),
      .mode_i       (mode_i[s]),
      .wr_areg_i    (wr_areg_i[s]),
      .dst_idx_i    (dst_idx_i[s]),
      .hazard_o     (hazard_o[s])
    );
  end

  agu_hzd_stall u_stall (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_en_i   (stall_en_i),
    .any_hazard_i (any_hazard),
    .stall_o      (stall_o)
  );
endmodule

// File: rtl/agu_exc_hazard_guard_chk.sv
module agu_exc_hazard_guard_chk #(
  parameter int NUM_SLOTS = 2,
  parameter int AREG_W    = 4,
  parameter int LOW_BANK  = 8,
  parameter int WINDOW    = 2,
  localparam int CNT_W    = $clog2(WINDOW + 1)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             exc_entry_i,
  input logic                             stall_en_i,
  input logic [NUM_SLOTS-1:0]             valid_i,
  input logic [NUM_SLOTS-1:0][AREG_W-1:0] areg_idx_i,
  input logic [NUM_SLOTS-1:0][1:0]        mode_i,
  input logic [NUM_SLOTS-1:0]             wr_areg_i,
  input logic [NUM_SLOTS-1:0][AREG_W-1:0] dst_idx_i,
  input logic [NUM_SLOTS-1:0]             hazard_o,
  input logic                             stall_o,
  input logic [CNT_W-1:0]                 win_cnt
);
  localparam logic [AREG_W-1:0] LOW_LIM = AREG_W'(LOW_BANK);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    AST_HIGH_BANK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hazard_o[s] && !wr_areg_i[s]) |-> (areg_idx_i[s] < LOW_LIM)); // R3
    AST_NO_UPDATE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_areg_i[s] && !mode_i[s][1]) |-> !hazard_o[s]); // R6
    AST_DST_HIGH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_areg_i[s] && dst_idx_i[s] >= LOW_LIM) |-> !hazard_o[s]); // R7
    AST_IDLE_SLOT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i[s] |-> !hazard_o[s]); // R10
    AST_CLOSED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_cnt == '0) |-> !hazard_o[s]); // R2
  end

  AST_WINDOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt <= CNT_W'(WINDOW)); // R2
  AST_ENTRY_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_entry_i |=> (win_cnt == CNT_W'(WINDOW))); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|valid_i) && !stall_o && !exc_entry_i) |=> $stable(win_cnt)); // R8
  AST_STALL_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_en_i && (|hazard_o)) |=> stall_o); // R11
  AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stall_en_i && (|hazard_o)) |=> !stall_o); // R11
endmodule

bind agu_exc_hazard_guard agu_exc_hazard_guard_chk #(
  .NUM_SLOTS(NUM_SLOTS), .AREG_W(AREG_W), .LOW_BANK(LOW_BANK), .WINDOW(WINDOW)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .exc_entry_i(exc_entry_i), .stall_en_i(stall_en_i),
  .valid_i(valid_i), .areg_idx_i(areg_idx_i), .mode_i(mode_i), .wr_areg_i(wr_areg_i),
  .dst_idx_i(dst_idx_i), .hazard_o(hazard_o), .stall_o(stall_o), .win_cnt(win_cnt)
);

// File: tb/agu_exc_hazard_guard_tb_top.sv
module agu_exc_hazard_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int AW = 4;
  localparam int WIN = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic exc_entry_i = 1'b0;
  logic stall_en_i = 1'b0;
  logic [NS-1:0] valid_i = '0;
  logic [NS-1:0][AW-1:0] areg_idx_i = '0;
  logic [NS-1:0][1:0] mode_i = '0;
  logic [NS-1:0] wr_areg_i = '0;
  logic [NS-1:0][AW-1:0] dst_idx_i = '0;
  logic [NS-1:0] hazard_o;
  logic stall_o;

  int checks = 0;
  int fails = 0;
  int m_cnt = 0;
  bit m_stall = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  agu_exc_hazard_guard dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .exc_entry_i(exc_entry_i), .stall_en_i(stall_en_i),
    .valid_i(valid_i), .areg_idx_i(areg_idx_i), .mode_i(mode_i), .wr_areg_i(wr_areg_i),
    .dst_idx_i(dst_idx_i), .hazard_o(hazard_o), .stall_o(stall_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic set_slot(input int s, input bit v, input int a, input int m,
                          input bit w, input int d);
    valid_i[s] = v;
    areg_idx_i[s] = AW'(a);
    mode_i[s] = 2'(m);
    wr_areg_i[s] = w;
    dst_idx_i[s] = AW'(d);
  endtask

  task automatic idle_slots();
    for (int s = 0; s < NS; s++) set_slot(s, 0, 0, 0, 0, 0);
  endtask

  function automatic bit rule_hit(input int s);
    if (wr_areg_i[s]) return int'(dst_idx_i[s]) < 8;
    return int'(areg_idx_i[s]) < 8 && (mode_i[s] == 2'b10 || mode_i[s] == 2'b11);
  endfunction

  // Called at a negedge with slots already set; returns at the next negedge.
  task automatic step(input string tag, input bit exc, input bit sen);
    logic [NS-1:0] exp_h;
    bit tick;
    exc_entry_i = exc;
    stall_en_i = sen;
    #1;
    for (int s = 0; s < NS; s++) exp_h[s] = valid_i[s] && m_cnt > 0 && rule_hit(s);
    check(tag, "hazard_o", int'(hazard_o), int'(exp_h));
    check(tag, "stall_o", int'(stall_o), int'(m_stall));
    @(posedge clk_i);
    tick = (|valid_i) || m_stall;
    if (exc) m_cnt = WIN;
    else if (m_cnt > 0 && tick) m_cnt--;
    m_stall = sen && (|exp_h);
    @(negedge clk_i);
    exc_entry_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    // R1: reset state, low-bank post-update presented while in reset
    set_slot(0, 1, 0, 2, 0, 0);
    repeat (2) @(negedge clk_i);
    #1;
    check("R1", "hazard_o in reset", int'(hazard_o), 0);
    check("R1", "stall_o in reset", int'(stall_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step("R1", 0, 1);  // window closed after reset
    // R2: full window then allowed
    idle_slots(); step("R2", 1, 0);
    set_slot(0, 1, 0, 2, 0, 0); step("R4", 0, 0);
    step("R2", 0, 0);
    step("R2", 0, 0);
    // R8: two nops consume the window
    idle_slots(); step("R8", 1, 0);
    set_slot(0, 1, 0, 0, 0, 0); step("R8", 0, 0);
    step("R8", 0, 0);
    set_slot(0, 1, 3, 2, 0, 0); step("R8", 0, 0);
    // R8: idle cycles do not consume
    idle_slots(); step("R8", 1, 0);
    step("R8", 0, 0);
    step("R8", 0, 0);
    set_slot(0, 1, 7, 2, 0, 0); step("R8", 0, 0);
    // R5 / R6
    idle_slots(); step("R5", 1, 0);
    set_slot(0, 1, 5, 3, 0, 0); step("R5", 0, 0);
    set_slot(0, 1, 0, 1, 0, 0); step("R6", 0, 0);
    idle_slots(); step("R6", 1, 0);
    set_slot(0, 1, 2, 1, 0, 0); set_slot(1, 1, 4, 0, 0, 0); step("R6", 0, 0);
    // R3: high bank with update modes
    idle_slots(); step("R3", 1, 0);
    set_slot(0, 1, 8, 2, 0, 0); set_slot(1, 1, 15, 3, 0, 0); step("R3", 0, 0);
    set_slot(0, 1, 12, 2, 0, 0); set_slot(1, 0, 0, 0, 0, 0); step("R3", 0, 0);
    // R7: destination decides
    idle_slots(); step("R7", 1, 0);
    set_slot(0, 1, 8, 0, 1, 1); step("R7", 0, 0);
    set_slot(0, 1, 1, 2, 1, 8); step("R7", 0, 0);
    idle_slots(); step("R7", 1, 0);
    set_slot(0, 1, 1, 3, 1, 15); set_slot(1, 1, 9, 0, 1, 6); step("R7", 0, 0);
    // R9: reload inside window, pulse with valid instruction
    idle_slots(); step("R9", 1, 0);
    set_slot(0, 1, 0, 2, 0, 0); step("R9", 0, 0);
    step("R9", 1, 0);
    step("R9", 0, 0);
    step("R9", 0, 0);
    // R10: dual slot, masked slot
    idle_slots(); step("R10", 1, 0);
    set_slot(0, 1, 0, 2, 0, 0); set_slot(1, 1, 1, 1, 0, 0); step("R10", 0, 0);
    set_slot(0, 0, 0, 2, 0, 0); set_slot(1, 1, 6, 3, 0, 0); step("R10", 0, 0);
    set_slot(0, 1, 0, 2, 0, 0); set_slot(1, 1, 6, 3, 0, 0); step("R10", 0, 0);
    // R11 / R12: stall mode
    idle_slots(); step("R11", 1, 1);
    set_slot(0, 1, 0, 2, 0, 0); step("R11", 0, 1);
    idle_slots(); step("R12", 0, 1);
    set_slot(0, 1, 0, 2, 0, 0); step("R12", 0, 1);
    step("R11", 0, 1);
    idle_slots(); step("R11", 1, 1);
    set_slot(0, 1, 4, 3, 0, 0); step("R11", 0, 1);
    step("R11", 0, 1);
    step("R11", 0, 1);
    step("R11", 0, 0);
    summary();
  end
endmodule